// File: doc/BRIEF.md
# Masked Debug Breakpoint Comparator

This block watches a processor's program counter and its operand bus and reports breakpoint hits. It holds four PC breakpoint values that share one PC mask, two address comparators and two data comparators. Each address comparator uses a low and a high bound and can match either one address or an inclusive range. The second address comparator is also qualified by a bus-attribute value with its own mask. Each data comparator has its own value and mask, and it is tied to the address comparator with the same index. In every mask, a bit set to 1 makes the matching bit don't-care.

Debug software loads all settings through a single register-write port. Every write replaces the whole 32-bit target register. Each comparator's hit is registered and appears one cycle after the valid sample that caused it. A combined trigger is the OR of all hit outputs. Trigger sequencing, core halting and exception generation belong to other blocks.

Top module: `bkpt_match`

## Requirements
- R1: After reset every hit output and `trigger` are 0 and every control bit is clear, so no comparator hits until the control register is written.
- R2: When `wr_en` is high at a rising edge, the register chosen by `wr_sel` takes all 32 bits of `wr_data`, and the new value applies to compares from the next cycle on. The select codes are: 0-3 PC breakpoints, 4 PC mask, 5/6 low/high of address comparator 0, 7/8 low/high of address comparator 1, 9 attribute value, 10 attribute mask, 11/12 data value/mask 0, 13/14 data value/mask 1, 15 control.
- R3: `pc_hit[k]` is 1 in the cycle after a cycle in which `pc_vld` is 1, PC enable k is set and `((pc ^ bp[k]) & ~pc_mask) == 0`. Otherwise it is 0.
- R4: The single PC mask applies to all four PC breakpoints. A mask bit of 1 removes that PC bit from the compare.
- R5: An address comparator in single mode hits when `bus_addr` equals its low register.
- R6: An address comparator in range mode hits when low <= `bus_addr` <= high, with both bounds included. Control bit 8+i selects range mode for comparator i.
- R7: Address comparator 1 additionally requires `((bus_attr ^ attr_val) & ~attr_mask) == 0`. Comparator 0 ignores `bus_attr`.
- R8: Data comparator i matches when `((bus_data ^ dval[i]) & ~dmask[i]) == 0`.
- R9: A data hit i also requires one of two conditions. Either address comparator i is enabled and matching on the same `bus_vld` sample, or the any-address bit, control bit 10+i, is set.
- R10: A comparator whose enable is clear never hits, and no hit appears without the matching valid strobe. The enable bits are: control bits 0-3 for PC, 4-5 for address, 6-7 for data.
- R11: `trigger` is 1 exactly when at least one of `pc_hit`, `addr_hit` or `data_hit` is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 32 | Register write data |
| pc | input | 32 | Current program counter |
| pc_vld | input | 1 | PC sample valid |
| bus_addr | input | 32 | Operand bus address |
| bus_attr | input | 8 | Operand bus attributes |
| bus_data | input | 32 | Operand bus data |
| bus_vld | input | 1 | Bus sample valid |
| pc_hit | output | 4 | Registered PC breakpoint hits |
| addr_hit | output | 2 | Registered address comparator hits |
| data_hit | output | 2 | Registered data comparator hits |
| trigger | output | 1 | OR of all hit outputs |

## Verification
The bench builds the block with its defaults: four PC breakpoints, two address/data comparator pairs, 8-bit attributes and the attribute check on comparator 1. This puts a disabled PC slot, a range comparator next to an attribute-qualified single comparator, and an address-bound data comparator next to an any-address one all within reach of a single configuration. The table covers both range edges, masked PC and attribute bits, and data matches with and without an address hit. Directed steps cover reset, a full rewrite, write-versus-compare ordering and clearing all enables.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Mask bit 1 = ignore that bit.
  function automatic logic masked_eq(word_t v, word_t r, word_t m);
    return ((v ^ r) & ~m) == '0;
  endfunction

  // Inclusive bounds on both sides.
  function automatic logic in_span(word_t a, word_t lo, word_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic addr_sel(logic rng, word_t a, word_t lo, word_t hi);
    return rng ? in_span(a, lo, hi) : (a == lo);
  endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int NUM_PC   = 4,
  parameter int NUM_ADDR = 2,
  parameter int ATTR_W   = 8,
  parameter int SEL_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  word_t                       wr_data,
  output logic [NUM_PC-1:0][WORD_W-1:0]   pc_bp,
  output word_t                       pc_mask,
  output logic [NUM_ADDR-1:0][WORD_W-1:0] a_lo,
  output logic [NUM_ADDR-1:0][WORD_W-1:0] a_hi,
  output logic [ATTR_W-1:0]           attr_val,
  output logic [ATTR_W-1:0]           attr_msk,
  output logic [NUM_ADDR-1:0][WORD_W-1:0] d_val,
  output logic [NUM_ADDR-1:0][WORD_W-1:0] d_msk,
  output logic [NUM_PC-1:0]           pc_en,
  output logic [NUM_ADDR-1:0]         a_en,
  output logic [NUM_ADDR-1:0]         d_en,
  output logic [NUM_ADDR-1:0]         a_rng,
  output logic [NUM_ADDR-1:0]         d_any
);
  localparam int IDX_PCM  = NUM_PC;
  localparam int IDX_A    = NUM_PC + 1;
  localparam int IDX_AV   = IDX_A + 2 * NUM_ADDR;
  localparam int IDX_AM   = IDX_AV + 1;
  localparam int IDX_D    = IDX_AM + 1;
  localparam int IDX_CTL  = IDX_D + 2 * NUM_ADDR;
  localparam int NUM_REGS = IDX_CTL + 1;
  localparam int C_AEN    = NUM_PC;
  localparam int C_DEN    = C_AEN + NUM_ADDR;
  localparam int C_RNG    = C_DEN + NUM_ADDR;
  localparam int C_ANY    = C_RNG + NUM_ADDR;
  localparam int C_END    = C_ANY + NUM_ADDR;

  word_t regs [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_REGS; k++) begin
      if (!rst_n)                                regs[k] <= '0;
      else if (wr_en && wr_sel == SEL_W'(k))     regs[k] <= wr_data;
    end
  end

  genvar gp, ga;
  generate
    for (gp = 0; gp < NUM_PC; gp++) begin : g_pc
      assign pc_bp[gp] = regs[gp];
    end
    for (ga = 0; ga < NUM_ADDR; ga++) begin : g_ad
      assign a_lo[ga]  = regs[IDX_A + 2*ga];
      assign a_hi[ga]  = regs[IDX_A + 2*ga + 1];
      assign d_val[ga] = regs[IDX_D + 2*ga];
      assign d_msk[ga] = regs[IDX_D + 2*ga + 1];
    end
  endgenerate

  assign pc_mask  = regs[IDX_PCM];
  assign attr_val = regs[IDX_AV][ATTR_W-1:0];
  assign attr_msk = regs[IDX_AM][ATTR_W-1:0];
  assign pc_en    = regs[IDX_CTL][NUM_PC-1:0];
  assign a_en     = regs[IDX_CTL][C_AEN +: NUM_ADDR];
  assign d_en     = regs[IDX_CTL][C_DEN +: NUM_ADDR];
  assign a_rng    = regs[IDX_CTL][C_RNG +: NUM_ADDR];
  assign d_any    = regs[IDX_CTL][C_ANY +: NUM_ADDR];

  // Stored but not decoded: kept so a write still replaces all bits.
  logic unused_bits;
  assign unused_bits = ^{regs[IDX_CTL][WORD_W-1:C_END],
                         regs[IDX_AV][WORD_W-1:ATTR_W],
                         regs[IDX_AM][WORD_W-1:ATTR_W]};

  genvar gk;
  generate
    for (gk = 0; gk < NUM_REGS; gk++) begin : g_chk
      assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(gk)) |=> regs[gk] == $past(wr_data));
    end
  endgenerate

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> regs[IDX_CTL] == '0);
endmodule

// File: rtl/bkpt_pc_cmp.sv
module bkpt_pc_cmp
  import bkpt_pkg::*;
#(
  parameter int NUM_PC = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  word_t                         pc,
  input  logic                          pc_vld,
  input  logic [NUM_PC-1:0][WORD_W-1:0] bp,
  input  word_t                         mask,
  input  logic [NUM_PC-1:0]             en,
  output logic [NUM_PC-1:0]             hit
);
  logic [NUM_PC-1:0] pc_match;

  genvar k;
  generate
    for (k = 0; k < NUM_PC; k++) begin : g_slot
      assign pc_match[k] = masked_eq(pc, bp[k], mask);

      always_ff @(posedge clk) begin
        if (!rst_n) hit[k] <= 1'b0;
        else        hit[k] <= pc_vld && en[k] && pc_match[k];
      end

      assert_pc_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit[k] |-> ($past(en[k]) && $past(pc_vld)));
      assert_pc_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit[k] |-> ((($past(pc) ^ $past(bp[k])) & ~$past(mask)) == '0));
    end
  endgenerate
endmodule

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp
  import bkpt_pkg::*;
#(
  parameter int NUM_ADDR = 2,
  parameter int ATTR_W   = 8,
  parameter int ATTR_IDX = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  word_t                           addr,
  input  logic [ATTR_W-1:0]               attr,
  input  logic                            vld,
  input  logic [NUM_ADDR-1:0][WORD_W-1:0] lo,
  input  logic [NUM_ADDR-1:0][WORD_W-1:0] hi,
  input  logic [ATTR_W-1:0]               attr_val,
  input  logic [ATTR_W-1:0]               attr_msk,
  input  logic [NUM_ADDR-1:0]             en,
  input  logic [NUM_ADDR-1:0]             rng,
  output logic [NUM_ADDR-1:0]             live,
  output logic [NUM_ADDR-1:0]             hit
);
  logic [NUM_ADDR-1:0] span_ok;
  logic [NUM_ADDR-1:0] attr_ok;

  genvar i;
  generate
    for (i = 0; i < NUM_ADDR; i++) begin : g_cmp
      assign span_ok[i] = addr_sel(rng[i], addr, lo[i], hi[i]);

      if (i == ATTR_IDX) begin : g_attr
        assign attr_ok[i] = masked_eq(WORD_W'(attr), WORD_W'(attr_val),
                                      WORD_W'(attr_msk));
      end else begin : g_noattr
        assign attr_ok[i] = 1'b1;
      end

      assign live[i] = vld && en[i] && span_ok[i] && attr_ok[i];

      always_ff @(posedge clk) begin
        if (!rst_n) hit[i] <= 1'b0;
        else        hit[i] <= live[i];
      end

      assert_addr_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit[i] |-> ($past(en[i]) && $past(vld)));
      assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[i] && $past(rng[i])) |->
          ($past(addr) >= $past(lo[i]) && $past(addr) <= $past(hi[i])));
      assert_addr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[i] && !$past(rng[i])) |-> $past(addr) == $past(lo[i]));
    end
  endgenerate
endmodule

// File: rtl/bkpt_data_cmp.sv
module bkpt_data_cmp
  import bkpt_pkg::*;
#(
  parameter int NUM_ADDR = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  word_t                           data,
  input  logic                            vld,
  input  logic [NUM_ADDR-1:0][WORD_W-1:0] dval,
  input  logic [NUM_ADDR-1:0][WORD_W-1:0] dmsk,
  input  logic [NUM_ADDR-1:0]             en,
  input  logic [NUM_ADDR-1:0]             any,
  input  logic [NUM_ADDR-1:0]             addr_live,
  output logic [NUM_ADDR-1:0]             hit
);
  logic [NUM_ADDR-1:0] data_match;
  logic [NUM_ADDR-1:0] qual_ok;

  genvar i;
  generate
    for (i = 0; i < NUM_ADDR; i++) begin : g_cmp
      assign data_match[i] = masked_eq(data, dval[i], dmsk[i]);
      assign qual_ok[i]    = any[i] || addr_live[i];

      always_ff @(posedge clk) begin
        if (!rst_n) hit[i] <= 1'b0;
        else        hit[i] <= vld && en[i] && data_match[i] && qual_ok[i];
      end

      assert_data_qual_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit[i] |-> ($past(any[i]) || $past(addr_live[i])));
      assert_data_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit[i] |-> ((($past(data) ^ $past(dval[i])) & ~$past(dmsk[i])) == '0));
    end
  endgenerate
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int NUM_PC   = 4,
  parameter int NUM_ADDR = 2,
  parameter int ATTR_W   = 8,
  parameter int ATTR_IDX = 1,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [31:0]         wr_data,
  input  logic [31:0]         pc,
  input  logic                pc_vld,
  input  logic [31:0]         bus_addr,
  input  logic [ATTR_W-1:0]   bus_attr,
  input  logic [31:0]         bus_data,
  input  logic                bus_vld,
  output logic [NUM_PC-1:0]   pc_hit,
  output logic [NUM_ADDR-1:0] addr_hit,
  output logic [NUM_ADDR-1:0] data_hit,
  output logic                trigger
);
  logic [NUM_PC-1:0][WORD_W-1:0]   pc_bp;
  word_t                           pc_mask;
  logic [NUM_ADDR-1:0][WORD_W-1:0] a_lo, a_hi, d_val, d_msk;
  logic [ATTR_W-1:0]               attr_val, attr_msk;
  logic [NUM_PC-1:0]               pc_en;
  logic [NUM_ADDR-1:0]             a_en, d_en, a_rng, d_any;
  logic [NUM_ADDR-1:0]             addr_live;

  bkpt_regs #(.NUM_PC(NUM_PC), .NUM_ADDR(NUM_ADDR), .ATTR_W(ATTR_W), .SEL_W(SEL_W))
  u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pc_bp(pc_bp), .pc_mask(pc_mask), .a_lo(a_lo), .a_hi(a_hi),
    .attr_val(attr_val), .attr_msk(attr_msk), .d_val(d_val), .d_msk(d_msk),
    .pc_en(pc_en), .a_en(a_en), .d_en(d_en), .a_rng(a_rng), .d_any(d_any)
  );

  bkpt_pc_cmp #(.NUM_PC(NUM_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .pc(pc), .pc_vld(pc_vld), .bp(pc_bp),
    .mask(pc_mask), .en(pc_en), .hit(pc_hit)
  );

  bkpt_addr_cmp #(.NUM_ADDR(NUM_ADDR), .ATTR_W(ATTR_W), .ATTR_IDX(ATTR_IDX)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .attr(bus_attr), .vld(bus_vld),
    .lo(a_lo), .hi(a_hi), .attr_val(attr_val), .attr_msk(attr_msk),
    .en(a_en), .rng(a_rng), .live(addr_live), .hit(addr_hit)
  );

  bkpt_data_cmp #(.NUM_ADDR(NUM_ADDR)) u_data (
    .clk(clk), .rst_n(rst_n), .data(bus_data), .vld(bus_vld), .dval(d_val),
    .dmsk(d_msk), .en(d_en), .any(d_any), .addr_live(addr_live), .hit(data_hit)
  );

  assign trigger = |{pc_hit, addr_hit, data_hit};

  assert_trig_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trigger) |-> $past(pc_vld || bus_vld));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !trigger);
endmodule

// File: tb/bkpt_match_bench.sv
module bkpt_match_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pc = '0;
  logic        pc_vld = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [7:0]  bus_attr = '0;
  logic [31:0] bus_data = '0;
  logic        bus_vld = 1'b0;
  logic [3:0]  pc_hit;
  logic [1:0]  addr_hit, data_hit;
  logic        trigger;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  bkpt_match u_bkpt_match (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pc(pc), .pc_vld(pc_vld), .bus_addr(bus_addr), .bus_attr(bus_attr),
    .bus_data(bus_data), .bus_vld(bus_vld), .pc_hit(pc_hit),
    .addr_hit(addr_hit), .data_hit(data_hit), .trigger(trigger)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic        pv;
    logic [31:0] addr;
    logic [7:0]  attr;
    logic [31:0] data;
    logic        bv;
    logic [3:0]  ep;
    logic [1:0]  ea;
    logic [1:0]  ed;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_1000, 1'b1, 32'h0,         8'h00, 32'h0,         1'b0, 4'b0001, 2'b00, 2'b00}, // R3 exact
    '{32'h0000_100F, 1'b1, 32'h0,         8'h00, 32'h0,         1'b0, 4'b0001, 2'b00, 2'b00}, // R4 masked low bits
    '{32'h0000_1010, 1'b1, 32'h0,         8'h00, 32'h0,         1'b0, 4'b0000, 2'b00, 2'b00}, // R4 unmasked bit differs
    '{32'h0000_3000, 1'b1, 32'h0,         8'h00, 32'h0,         1'b0, 4'b0100, 2'b00, 2'b00}, // R4 bp bits masked
    '{32'h8000_0000, 1'b1, 32'h0,         8'h00, 32'h0,         1'b0, 4'b0000, 2'b00, 2'b00}, // R10 slot 3 disabled
    '{32'h0000_2000, 1'b0, 32'h0,         8'h00, 32'h0,         1'b0, 4'b0000, 2'b00, 2'b00}, // R10 no pc_vld
    '{32'h0,         1'b0, 32'h0000_0100, 8'h00, 32'hDEAD_BEEF, 1'b1, 4'b0000, 2'b01, 2'b01}, // R6 low edge, R9
    '{32'h0,         1'b0, 32'h0000_01FF, 8'h00, 32'h1234_ABCD, 1'b1, 4'b0000, 2'b01, 2'b10}, // R6 high edge, R8
    '{32'h0,         1'b0, 32'h0000_0200, 8'h00, 32'hDEAD_BEEF, 1'b1, 4'b0000, 2'b00, 2'b00}, // R6 above, R9 no addr
    '{32'h0,         1'b0, 32'h0000_00FF, 8'h00, 32'hDEAD_BEEF, 1'b1, 4'b0000, 2'b00, 2'b00}, // R6 below
    '{32'h0,         1'b0, 32'h0000_4000, 8'h35, 32'h0,         1'b1, 4'b0000, 2'b10, 2'b00}, // R5, R7 masked attr
    '{32'h0,         1'b0, 32'h0000_4000, 8'h06, 32'h0,         1'b1, 4'b0000, 2'b00, 2'b00}, // R7 attr mismatch
    '{32'h0,         1'b0, 32'h0000_4001, 8'h05, 32'h0,         1'b1, 4'b0000, 2'b00, 2'b00}, // R5 off by one
    '{32'h0,         1'b0, 32'h0000_0150, 8'hFF, 32'hDEAD_BEEF, 1'b1, 4'b0000, 2'b01, 2'b01}, // R7 comp0 ignores attr
    '{32'h0000_2005, 1'b1, 32'h0000_0150, 8'h00, 32'h1234_0001, 1'b1, 4'b0010, 2'b01, 2'b10}, // R3+R8 together
    '{32'h0,         1'b0, 32'h0000_0300, 8'h00, 32'h1234_FFFF, 1'b1, 4'b0000, 2'b00, 2'b10}  // R9 any-address
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] val);
    pc_vld = 1'b0; bus_vld = 1'b0;
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_bus();
    pc_vld = 1'b0; bus_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc_hit", 32'(pc_hit), 32'h0);
    chk("R1 addr_hit", 32'(addr_hit), 32'h0);
    chk("R1 data_hit", 32'(data_hit), 32'h0);
    chk("R1 trigger", 32'(trigger), 32'h0);

    // R1 enables clear after reset: a loaded breakpoint must not hit
    wr(4'd0, 32'h0000_1000);
    pc = 32'h0000_1000; pc_vld = 1'b1;
    @(negedge clk);
    chk("R1 enables clear pc_hit", 32'(pc_hit), 32'h0);
    chk("R1 enables clear trigger", 32'(trigger), 32'h0);

    wr(4'd1, 32'h0000_2000);
    wr(4'd2, 32'h0000_3004);
    wr(4'd3, 32'h8000_0000);
    wr(4'd4, 32'h0000_000F);
    wr(4'd5, 32'h0000_0100);
    wr(4'd6, 32'h0000_01FF);
    wr(4'd7, 32'h0000_4000);
    wr(4'd8, 32'h0000_0000);
    wr(4'd9, 32'h0000_0005);
    wr(4'd10, 32'h0000_00F0);
    wr(4'd11, 32'hDEAD_BEEF);
    wr(4'd12, 32'h0000_0000);
    wr(4'd13, 32'h1234_0000);
    wr(4'd14, 32'h0000_FFFF);
    wr(4'd15, 32'h0000_09F7);

    for (int i = 0; i < NV; i++) begin
      pc = VEC[i].pc; pc_vld = VEC[i].pv;
      bus_addr = VEC[i].addr; bus_attr = VEC[i].attr;
      bus_data = VEC[i].data; bus_vld = VEC[i].bv;
      @(negedge clk);
      chk($sformatf("vec%0d pc_hit R3", i), 32'(pc_hit), 32'(VEC[i].ep));
      chk($sformatf("vec%0d addr_hit R5", i), 32'(addr_hit), 32'(VEC[i].ea));
      chk($sformatf("vec%0d data_hit R8", i), 32'(data_hit), 32'(VEC[i].ed));
      chk($sformatf("vec%0d trigger R11", i), 32'(trigger),
          32'(|{VEC[i].ep, VEC[i].ea, VEC[i].ed}));
    end
    idle_bus();
    @(negedge clk);
    chk("R10 idle no hit", 32'(trigger), 32'h0);

    // R2 full rewrite: old value gone, new value (masked) hits
    wr(4'd0, 32'h0000_5000);
    pc = 32'h0000_1000; pc_vld = 1'b1;
    @(negedge clk);
    chk("R2 old value replaced", 32'(pc_hit), 32'h0);
    pc = 32'h0000_5003;
    @(negedge clk);
    chk("R2 new value hits", 32'(pc_hit), 32'h1);

    // R2 a write applies from the next cycle on
    wr_en = 1'b1; wr_sel = 4'd0; wr_data = 32'h0000_6000;
    pc = 32'h0000_6000; pc_vld = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 same-cycle compare uses old", 32'(pc_hit), 32'h0);
    @(negedge clk);
    chk("R2 next-cycle compare uses new", 32'(pc_hit), 32'h1);
    chk("R11 trigger with pc hit", 32'(trigger), 32'h1);

    // R10 clearing all enables silences every comparator
    wr(4'd15, 32'h0000_0000);
    pc = 32'h0000_6000; pc_vld = 1'b1;
    bus_addr = 32'h0000_0100; bus_attr = 8'h00; bus_data = 32'h1234_0000; bus_vld = 1'b1;
    @(negedge clk);
    chk("R10 disabled pc_hit", 32'(pc_hit), 32'h0);
    chk("R10 disabled addr_hit", 32'(addr_hit), 32'h0);
    chk("R10 disabled data_hit", 32'(data_hit), 32'h0);
    chk("R11 trigger quiet", 32'(trigger), 32'h0);
    idle_bus();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule